// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The combiner takes a wide bank of level-sensitive interrupt lines and folds them into a much smaller set of group outputs. By default it has 512 sources in 64 groups of eight. A group output is high whenever at least one of its sources is both enabled and asserted. An interrupt distributor downstream sees one line per group rather than one line per source.

Software controls the block through a synchronous 32-bit register port. Each 16-byte quad of the window serves four neighbouring groups, one byte per group. Enables are changed only through separate write-one-to-set and write-one-to-clear words, so a change to one source never needs a read-modify-write. Two status words in each quad show the raw source levels and the enabled levels. Summary words after the last quad hold one bit per group output.

A build option marks the block as an external instance. In that case only the lowest groups, up to a configured count, accept their inputs, and the rest stay permanently quiet.

Top module: `irq_combiner`

## Requirements
- R1: Source line n belongs to group n/8 (n shifted right by 3) at bit position n mod 8 (the low 3 bits of n) within that group.
- R2: Group output g is high exactly when the AND of the group's enable byte and pending byte is nonzero. It follows an input change or an enable write one clock edge later.
- R3: A pending bit copies the level of its source on every clock edge. Nothing is latched, so a source that drops clears its pending bit and, one edge later, the group output.
- R4: The register offset is decoded as follows: offset bits above bit 3 give the quad index q (groups 4q to 4q+3), and bits 3:2 pick the word inside the quad. Bits 1:0 are ignored.
- R5: Writing word 0 of quad q ORs byte k of the data (bits 8k+7:8k) into the enable byte of group 4q+k. Enable bits that were already set stay set.
- R6: Writing word 1 of quad q clears each enable bit of group 4q+k whose matching bit in byte k of the data is 1. Other enable bits keep their value.
- R7: Reading word 2 of quad q returns the pending byte of group 4q+k in bits 8k+7:8k.
- R8: Reading word 3 of quad q returns the same layout with each pending byte ANDed with its enable byte.
- R9: The summary words start at offset 0x100, right after the 16 quads. Word 0 (0x100) holds group g's output at bit g for groups 0 to 31. Word 1 (0x104) holds groups 32 to 63 at bit g-32.
- R10: A write to word 2 or word 3 of any quad, or to any offset at or above 0x100, changes no enable. It raises wr_err for exactly the one cycle after the write.
- R11: Read data appears in the cycle after the read request. Reading word 0 or word 1 of a quad, or any offset at or above 0x108, returns zero.
- R12: Reset clears every enable bit, every pending bit, every group output and wr_err.
- R13: When EXT_MODE is set, groups at or above EXT_MAX_GROUPS ignore their inputs. Their pending bytes read as zero and their outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_GROUPS*8 | Level-sensitive interrupt sources |
| wr_en_i | input | 1 | Write request for this cycle |
| rd_en_i | input | 1 | Read request for this cycle |
| addr_i | input | ADDR_W | Byte offset in the register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |
| wr_err_o | output | 1 | One-cycle pulse after an illegal write |
| grp_irq_o | output | NUM_GROUPS | One combined interrupt per group |

## Verification
With every enable set, a single high source is walked across all 512 lines. This separates a correct group and bit mapping from any off-by-one or byte-swap in the group outputs and in the raw status words. With all sources high, partial clear patterns and then set patterns are applied. These show whether set ORs and clear masks act per bit and per group, and they are compared through the masked status and the summary words. Illegal writes, offsets with their low bits set, undefined reads and a mid-run reset probe the decode edges. A second instance built with the external option, driven by the same stimulus, shows that the upper groups stay silent while the lower ones behave normally.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   localparam int BYTE_W    = 8;
   localparam int WORD_W    = 32;
   localparam int QUAD_GRPS = WORD_W / BYTE_W;
   localparam int QUAD_BYTES = 16;

   typedef enum logic [1:0] {
      QW_EN_SET  = 2'd0,
      QW_EN_CLR  = 2'd1,
      QW_RAW     = 2'd2,
      QW_MASKED  = 2'd3
   } quad_word_e;

   function automatic int unsigned sum_words(input int unsigned groups);
      return (groups + WORD_W - 1) / WORD_W;
   endfunction

   function automatic int unsigned window_bytes(input int unsigned groups);
      return (groups / QUAD_GRPS) * QUAD_BYTES + sum_words(groups) * (WORD_W / 8);
   endfunction

endpackage

// File: rtl/irqc_group.sv
module irqc_group #(
   parameter int SRC_W  = 8,
   parameter bit IGNORE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] src_i,
   input  logic             set_i,
   input  logic             clr_i,
   input  logic [SRC_W-1:0] wbyte_i,
   output logic [SRC_W-1:0] en_o,
   output logic [SRC_W-1:0] pend_o,
   output logic             irq_o
);

   logic [SRC_W-1:0] en_q;
   logic [SRC_W-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (set_i) begin
         en_q <= en_q | wbyte_i;
      end else if (clr_i) begin
         en_q <= en_q & ~wbyte_i;
      end
   end

   generate
      if (IGNORE) begin : g_quiet
         logic unused_src;
         assign unused_src = ^src_i;
         assign pend_q     = '0;
      end else begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q <= '0;
            else        pend_q <= src_i;
         end

         assert_pend_follows_R3 : assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (pend_q == $past(src_i)));
      end
   endgenerate

   assign en_o   = en_q;
   assign pend_o = pend_q;
   assign irq_o  = |(en_q & pend_q);

   assert_set_or_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> ((en_q & $past(wbyte_i)) == $past(wbyte_i)) &&
                ((en_q & $past(en_q)) == $past(en_q)));

   assert_clr_mask_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> ((en_q & $past(wbyte_i)) == '0) &&
                            ((en_q & ~$past(wbyte_i)) == ($past(en_q) & ~$past(wbyte_i))));

   assert_en_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(en_q));

endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
   import irqc_pkg::*;
#(
   parameter int NUM_GROUPS = 64,
   parameter int ADDR_W     = 9
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en_i,
   input  logic [ADDR_W-1:0]     addr_i,
   output logic [NUM_GROUPS-1:0] set_o,
   output logic [NUM_GROUPS-1:0] clr_o,
   output logic                  wr_err_o
);

   localparam int unsigned NUM_QUADS = NUM_GROUPS / QUAD_GRPS;
   localparam int unsigned QUAD_END  = NUM_QUADS * QUAD_BYTES;

   int unsigned a_u;
   int unsigned quad;
   quad_word_e  word;
   logic        legal;
   logic        err_q;

   always_comb begin
      a_u   = 32'(addr_i);
      quad  = a_u / QUAD_BYTES;
      word  = quad_word_e'(addr_i[3:2]);
      legal = (a_u < QUAD_END) && ((word == QW_EN_SET) || (word == QW_EN_CLR));
      for (int g = 0; g < NUM_GROUPS; g++) begin
         set_o[g] = wr_en_i && legal && (word == QW_EN_SET) && (quad == g / QUAD_GRPS);
         clr_o[g] = wr_en_i && legal && (word == QW_EN_CLR) && (quad == g / QUAD_GRPS);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= wr_en_i && !legal;
   end

   assign wr_err_o = err_q;

   assert_err_needs_write_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> !wr_err_o);

   assert_single_action_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({|set_o, |clr_o}));

   assert_strobe_quad_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(set_o) == 0) || ($countones(set_o) == QUAD_GRPS));

endmodule

// File: rtl/irqc_rdmux.sv
module irqc_rdmux
   import irqc_pkg::*;
#(
   parameter int NUM_GROUPS = 64,
   parameter int ADDR_W     = 9
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           rd_en_i,
   input  logic [ADDR_W-1:0]              addr_i,
   input  logic [NUM_GROUPS*BYTE_W-1:0]   en_i,
   input  logic [NUM_GROUPS*BYTE_W-1:0]   pend_i,
   input  logic [NUM_GROUPS-1:0]          irq_i,
   output logic [WORD_W-1:0]              rdata_o
);

   localparam int unsigned NUM_QUADS = NUM_GROUPS / QUAD_GRPS;
   localparam int unsigned NUM_SUM   = sum_words(NUM_GROUPS);
   localparam int unsigned SUM_BASE  = NUM_QUADS * QUAD_BYTES;
   localparam int unsigned WIN       = window_bytes(NUM_GROUPS);

   logic [NUM_SUM*WORD_W-1:0] sum_pad;
   logic [WORD_W-1:0]         rd_next;
   logic [WORD_W-1:0]         rdata_q;
   int unsigned               a_u;
   int unsigned               quad;
   int unsigned               sidx;

   always_comb begin
      sum_pad                 = '0;
      sum_pad[NUM_GROUPS-1:0] = irq_i;
      a_u     = 32'(addr_i);
      quad    = a_u / QUAD_BYTES;
      sidx    = 0;
      rd_next = '0;
      if (a_u < SUM_BASE) begin
         case (quad_word_e'(addr_i[3:2]))
            QW_RAW:    rd_next = pend_i[quad*WORD_W +: WORD_W];
            QW_MASKED: rd_next = pend_i[quad*WORD_W +: WORD_W] & en_i[quad*WORD_W +: WORD_W];
            default:   rd_next = '0;
         endcase
      end else if (a_u < WIN) begin
         sidx    = (a_u - SUM_BASE) / 4;
         rd_next = sum_pad[sidx*WORD_W +: WORD_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata_q <= '0;
      else if (rd_en_i) rdata_q <= rd_next;
   end

   assign rdata_o = rdata_q;

   assert_undef_zero_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && (32'(addr_i) >= WIN)) |=> (rdata_o == '0));

   assert_rdata_hold_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |=> $stable(rdata_o));

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
   import irqc_pkg::*;
#(
   parameter int NUM_GROUPS     = 64,
   parameter int SRCS_PER_GROUP = 8,
   parameter int ADDR_W         = 9,
   parameter int DATA_W         = 32,
   parameter bit EXT_MODE       = 1'b0,
   parameter int EXT_MAX_GROUPS = 16
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [NUM_GROUPS*SRCS_PER_GROUP-1:0] src_i,
   input  logic                               wr_en_i,
   input  logic                               rd_en_i,
   input  logic [ADDR_W-1:0]                  addr_i,
   input  logic [DATA_W-1:0]                  wdata_i,
   output logic [DATA_W-1:0]                  rdata_o,
   output logic                               wr_err_o,
   output logic [NUM_GROUPS-1:0]              grp_irq_o
);

   localparam int NUM_SRCS = NUM_GROUPS * SRCS_PER_GROUP;
   localparam int WIN      = int'(window_bytes(NUM_GROUPS));

   generate
      if (SRCS_PER_GROUP != BYTE_W) begin : g_chk_width
         $error("SRCS_PER_GROUP must equal one byte");
      end
      if (DATA_W != WORD_W) begin : g_chk_data
         $error("DATA_W must be 32");
      end
      if ((NUM_GROUPS % QUAD_GRPS) != 0 || NUM_GROUPS < QUAD_GRPS) begin : g_chk_groups
         $error("NUM_GROUPS must be a nonzero multiple of 4");
      end
      if (ADDR_W < $clog2(WIN)) begin : g_chk_addr
         $error("ADDR_W too narrow for the register window");
      end
      if (EXT_MODE && (EXT_MAX_GROUPS > NUM_GROUPS)) begin : g_chk_ext
         $error("EXT_MAX_GROUPS exceeds NUM_GROUPS");
      end
   endgenerate

   logic [NUM_GROUPS-1:0] set_stb;
   logic [NUM_GROUPS-1:0] clr_stb;
   logic [NUM_SRCS-1:0]   en_flat;
   logic [NUM_SRCS-1:0]   pend_flat;
   logic [NUM_GROUPS-1:0] irq_vec;

   irqc_regif #(
      .NUM_GROUPS (NUM_GROUPS),
      .ADDR_W     (ADDR_W)
   ) u_regif (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (wr_en_i),
      .addr_i   (addr_i),
      .set_o    (set_stb),
      .clr_o    (clr_stb),
      .wr_err_o (wr_err_o)
   );

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
         localparam bit QUIET = EXT_MODE && (g >= EXT_MAX_GROUPS);
         irqc_group #(
            .SRC_W  (SRCS_PER_GROUP),
            .IGNORE (QUIET)
         ) u_group (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (src_i[g*SRCS_PER_GROUP +: SRCS_PER_GROUP]),
            .set_i   (set_stb[g]),
            .clr_i   (clr_stb[g]),
            .wbyte_i (wdata_i[(g % QUAD_GRPS)*BYTE_W +: BYTE_W]),
            .en_o    (en_flat[g*SRCS_PER_GROUP +: SRCS_PER_GROUP]),
            .pend_o  (pend_flat[g*SRCS_PER_GROUP +: SRCS_PER_GROUP]),
            .irq_o   (irq_vec[g])
         );
      end
   endgenerate

   irqc_rdmux #(
      .NUM_GROUPS (NUM_GROUPS),
      .ADDR_W     (ADDR_W)
   ) u_rdmux (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en_i (rd_en_i),
      .addr_i  (addr_i),
      .en_i    (en_flat),
      .pend_i  (pend_flat),
      .irq_i   (irq_vec),
      .rdata_o (rdata_o)
   );

   assign grp_irq_o = irq_vec;

   assert_out_lags_src_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $stable(en_flat) && (src_i == '0)) |=> (grp_irq_o == '0));

endmodule

// File: tb/irq_combiner_tb.sv
module irq_combiner_tb;

   localparam int NG = 64;
   localparam int NI = NG * 8;
   localparam int AW = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NI-1:0] src = '0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata, rdata_x;
   logic          wr_err, wr_err_x;
   logic [NG-1:0] grp, grp_x;

   int checks = 0;
   int errors = 0;
   logic [31:0] rd_v, rd_vx;
   logic        err_seen;

   always #10 clk = ~clk;

   irq_combiner u_dut (
      .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .wr_err_o(wr_err), .grp_irq_o(grp)
   );

   irq_combiner #(.EXT_MODE(1'b1), .EXT_MAX_GROUPS(16)) u_dut_ext (
      .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_x), .wr_err_o(wr_err_x), .grp_irq_o(grp_x)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
      err_seen = wr_err;
   endtask

   task automatic do_read(input logic [AW-1:0] a);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      rd_v  = rdata;
      rd_vx = rdata_x;
   endtask

   task automatic set_src(input logic [NI-1:0] v);
      @(negedge clk);
      src = v;
      @(negedge clk);
   endtask

   function automatic logic [AW-1:0] qaddr(input int q, input int w);
      return AW'(q * 16 + w * 4);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R12 reset grp", grp, 64'h0);
      chk("R12 reset err", 64'(wr_err), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      do_read(qaddr(0, 3));
      chk("R12 reset masked", 64'(rd_v), 64'h0);

      // enable everything
      for (int q = 0; q < NG / 4; q++) do_write(qaddr(q, 0), 32'hFFFF_FFFF);
      chk("R10 legal write no err", 64'(err_seen), 64'h0);

      // walking one across every source
      for (int n = 0; n < NI; n++) begin
         set_src({{(NI-1){1'b0}}, 1'b1} << n);
         chk("R1 R2 walk grp", grp, 64'h1 << (n / 8));
         chk("R13 walk ext grp", grp_x, ((n / 8) < 16) ? (64'h1 << (n / 8)) : 64'h0);
         do_read(qaddr(n / 32, 2));
         chk("R7 walk raw", 64'(rd_v), 64'(32'h1 << (n % 32)));
      end

      // all sources high
      set_src('1);
      chk("R2 all grp", grp, '1);
      chk("R13 ext grp", grp_x, 64'h0000_0000_0000_FFFF);
      do_read(qaddr(5, 3));
      chk("R8 masked all", 64'(rd_v), 64'hFFFF_FFFF);
      do_read(qaddr(4, 2));
      chk("R13 ext raw quiet", 64'(rd_vx), 64'h0);
      chk("R7 raw quad4", 64'(rd_v), 64'hFFFF_FFFF);
      do_read(AW'(9'h100));
      chk("R9 sum0 all", 64'(rd_v), 64'hFFFF_FFFF);
      chk("R13 ext sum0", 64'(rd_vx), 64'h0000_FFFF);
      do_read(AW'(9'h104));
      chk("R9 sum1 all", 64'(rd_v), 64'hFFFF_FFFF);

      // partial clears
      for (int q = 0; q < NG / 4; q++) do_write(qaddr(q, 1), 32'h0F0F_0F0F);
      do_read(qaddr(5, 3));
      chk("R6 masked after clr", 64'(rd_v), 64'hF0F0_F0F0);
      do_read(qaddr(5, 2));
      chk("R7 raw after clr", 64'(rd_v), 64'hFFFF_FFFF);
      chk("R2 grp after part clr", grp, '1);
      do_write(qaddr(0, 1), 32'hF0F0_F0F0);
      chk("R2 R6 grp quad0 off", grp, ~64'hF);
      do_read(AW'(9'h100));
      chk("R9 sum0 partial", 64'(rd_v), 64'hFFFF_FFF0);
      do_read(AW'(9'h104));
      chk("R9 sum1 partial", 64'(rd_v), 64'hFFFF_FFFF);

      // set ORs, with low address bits set
      do_write(AW'(9'h003), 32'h0000_0001);
      chk("R4 R5 grp0 on", grp, ~64'hE);
      do_write(qaddr(0, 0), 32'h0000_0002);
      do_read(AW'(qaddr(0, 3) | 9'h3));
      chk("R5 R4 masked OR", 64'(rd_v), 64'h0000_0003);

      // illegal writes
      do_write(qaddr(0, 2), 32'hFFFF_FFFF);
      chk("R10 err pulse raw", 64'(err_seen), 64'h1);
      @(negedge clk);
      chk("R10 err one cycle", 64'(wr_err), 64'h0);
      do_write(qaddr(0, 3), 32'hFFFF_FFFF);
      chk("R10 err pulse masked", 64'(err_seen), 64'h1);
      do_read(qaddr(0, 3));
      chk("R10 enables kept", 64'(rd_v), 64'h0000_0003);
      do_write(AW'(9'h100), 32'hFFFF_FFFF);
      chk("R10 err pulse summary", 64'(err_seen), 64'h1);
      do_read(AW'(9'h100));
      chk("R10 R9 sum0 kept", 64'(rd_v), 64'hFFFF_FFF1);
      do_write(qaddr(0, 0), 32'h0);
      chk("R10 legal no err", 64'(err_seen), 64'h0);

      // undefined reads
      do_read(AW'(9'h108));
      chk("R11 undef 0x108", 64'(rd_v), 64'h0);
      do_read(AW'(9'h1FC));
      chk("R11 undef 0x1FC", 64'(rd_v), 64'h0);
      do_read(qaddr(2, 0));
      chk("R11 set word reads 0", 64'(rd_v), 64'h0);
      do_read(qaddr(2, 1));
      chk("R11 clr word reads 0", 64'(rd_v), 64'h0);

      // levels, no latching
      set_src('0);
      chk("R3 grp drops", grp, 64'h0);
      do_read(qaddr(3, 2));
      chk("R3 raw drops", 64'(rd_v), 64'h0);

      // mid-run reset
      set_src('1);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk("R12 grp in reset", grp, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 grp after reset", grp, 64'h0);
      do_read(qaddr(0, 2));
      chk("R12 R3 raw after reset", 64'(rd_v), 64'hFFFF_FFFF);
      do_read(qaddr(0, 3));
      chk("R12 masked after reset", 64'(rd_v), 64'h0);

      summary();
      $finish;
   end

endmodule